// File: doc/BRIEF.md
# Receive Frame Size Error Counters

This block sits downstream of an Ethernet receive MAC. Each received frame ends with a one-cycle end-of-frame strobe. The strobe comes with the frame's byte length, measured from the first destination-address byte through the last CRC byte inclusive. It also comes with a set of flags produced elsewhere: CRC good, address filter passed, flow-control frame, and no buffer or queue disabled. The block sorts every qualifying frame into error classes and counts each class in its own saturating statistics counter.

A global receive-enable bit and the address-filter result gate every counter. Frames shorter than 64 bytes go to one of two classes, chosen by CRC validity. Frames longer than the programmed maximum size, sampled at end of frame, count as oversize. Frames that found no buffer count as missed, unless they are flow-control frames. Software reads a counter by pulsing a read enable with a counter index. The value appears one cycle later, and reading clears the counter.

Top module: `rx_size_err_stats`

## Requirements
- R1: After reset every counter is zero and the read data output is zero.
- R2: A frame with receive enabled, address filter passed, length below 64 and good CRC adds one to the undersize counter (index 0).
- R3: A frame with receive enabled, address filter passed, length below 64 and bad CRC adds one to the fragment counter (index 1) and never to the undersize counter.
- R4: A frame with receive enabled, address filter passed and length strictly above the maximum-size input, sampled in the end-of-frame cycle, adds one to the oversize counter (index 2), whatever its CRC.
- R5: A frame with receive enabled, address filter passed and the no-buffer flag set adds one to the missed counter (index 3), unless the flow-control flag is set, in which case the missed counter is unchanged.
- R6: While receive enable is low, or for frames that fail address filtering, no counter changes.
- R7: A read pulse with an index returns that counter's value on the read data output in the next cycle, and the counter becomes zero.
- R8: When a read and an increment of the same counter fall in one cycle, the read returns the pre-increment value and the counter becomes 1.
- R9: A counter at its all-ones value stays there on further increments.
- R10: Side inputs have no effect in cycles where the end-of-frame strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| eofValid | input | 1 | End-of-frame strobe, one cycle per frame |
| frameLen | input | LEN_W | Frame length in bytes, destination address through CRC |
| crcOk | input | 1 | CRC check passed |
| addrPass | input | 1 | Address filter passed |
| isPause | input | 1 | Frame is a flow-control frame |
| noBuf | input | 1 | Target queue had no buffer or was disabled |
| rxEnable | input | 1 | Global receive enable |
| maxLen | input | LEN_W | Programmed maximum frame size in bytes |
| rdEn | input | 1 | Counter read pulse |
| rdAddr | input | ADDR_W | Counter index: 0 undersize, 1 fragment, 2 oversize, 3 missed |
| rdData | output | CNT_W | Read value, valid the cycle after rdEn |

## Verification
The assertions check several properties on every cycle. The undersize and fragment strobes never fire together. A flow-control frame never raises the missed strobe. A counter with no strobe and no read holds its value. A read leaves its counter at zero or one. A saturated counter never wraps. The actual classification against lengths and flags can only be shown by the bench's sweeps. These sweeps cross boundary lengths with every flag combination under two maximum sizes. The pre-increment read value and the saturation count are likewise shown by directed scenarios, which compare the values returned at the read port.

// File: rtl/rxszs_pkg.sv
package rxszs_pkg;
  localparam int NUM_CLASS = 4;

  typedef enum logic [1:0] {
    CLS_UNDER = 2'd0,
    CLS_FRAG  = 2'd1,
    CLS_OVER  = 2'd2,
    CLS_MISS  = 2'd3
  } cls_e;

  // bit i of the packed struct is the strobe for counter index i
  typedef struct packed {
    logic incMiss;
    logic incOver;
    logic incFrag;
    logic incUnder;
  } incStrobe_t;
endpackage

// File: rtl/rxszs_ctrl.sv
module rxszs_ctrl
  import rxszs_pkg::*;
#(
  parameter int LEN_W   = 16,
  parameter int MIN_LEN = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             eofValid,
  input  logic [LEN_W-1:0] frameLen,
  input  logic             crcOk,
  input  logic             addrPass,
  input  logic             isPause,
  input  logic             noBuf,
  input  logic             rxEnable,
  input  logic [LEN_W-1:0] maxLen,
  output incStrobe_t       strb
);
  localparam logic [LEN_W-1:0] MinLenV = LEN_W'(MIN_LEN);

  logic qualified;
  logic isShort;
  logic isLong;

  always_comb begin
    qualified     = eofValid && rxEnable && addrPass;
    isShort       = frameLen < MinLenV;
    isLong        = frameLen > maxLen;
    strb          = '0;
    strb.incUnder = qualified && isShort && crcOk;
    strb.incFrag  = qualified && isShort && !crcOk;
    strb.incOver  = qualified && isLong;
    strb.incMiss  = qualified && noBuf && !isPause;
  end

  AST_PAUSE_NO_MISS: assert property (@(posedge clk) disable iff (!rstN)
    (eofValid && isPause) |-> !strb.incMiss); // R5

  AST_OFF_NO_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (!rxEnable || !eofValid || !addrPass) |-> (strb == '0)); // R6
endmodule

// File: rtl/rxszs_dpath.sv
module rxszs_dpath
  import rxszs_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int NUM_CNT = NUM_CLASS,
  parameter int ADDR_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  incStrobe_t        strb,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [CNT_W-1:0]  rdData
);
  localparam logic [CNT_W-1:0] CntMax = '1;

  logic [NUM_CNT-1:0] incVec;
  logic [CNT_W-1:0]   cntQ [NUM_CNT];

  assign incVec = NUM_CNT'(strb);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_CNT; i++) cntQ[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_CNT; i++) begin
        if (rdEn && rdAddr == ADDR_W'(i))
          cntQ[i] <= incVec[i] ? CNT_W'(1) : '0;
        else if (incVec[i] && cntQ[i] != CntMax)
          cntQ[i] <= cntQ[i] + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)     rdData <= '0;
    else if (rdEn) rdData <= cntQ[rdAddr];
  end

  AST_SHORT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.incUnder && strb.incFrag)); // R3

  for (genvar g = 0; g < NUM_CNT; g++) begin : gChk
    AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
      (rdEn && rdAddr == ADDR_W'(g)) |=> (cntQ[g] <= CNT_W'(1))); // R7
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
      (cntQ[g] == CntMax && !(rdEn && rdAddr == ADDR_W'(g))) |=> (cntQ[g] == CntMax)); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      (!incVec[g] && !(rdEn && rdAddr == ADDR_W'(g))) |=> $stable(cntQ[g])); // R10
  end
endmodule

// File: rtl/rx_size_err_stats.sv
module rx_size_err_stats
  import rxszs_pkg::*;
#(
  parameter int LEN_W   = 16,
  parameter int CNT_W   = 32,
  parameter int MIN_LEN = 64,
  parameter int ADDR_W  = $clog2(NUM_CLASS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              eofValid,
  input  logic [LEN_W-1:0]  frameLen,
  input  logic              crcOk,
  input  logic              addrPass,
  input  logic              isPause,
  input  logic              noBuf,
  input  logic              rxEnable,
  input  logic [LEN_W-1:0]  maxLen,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [CNT_W-1:0]  rdData
);
  incStrobe_t strb;

  rxszs_ctrl #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_ctrl (
    .clk(clk), .rstN(rstN), .eofValid(eofValid), .frameLen(frameLen),
    .crcOk(crcOk), .addrPass(addrPass), .isPause(isPause), .noBuf(noBuf),
    .rxEnable(rxEnable), .maxLen(maxLen), .strb(strb)
  );

  rxszs_dpath #(.CNT_W(CNT_W), .NUM_CNT(NUM_CLASS), .ADDR_W(ADDR_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .rdEn(rdEn), .rdAddr(rdAddr),
    .rdData(rdData)
  );
endmodule

// File: tb/rx_size_err_stats_tb.sv
module rx_size_err_stats_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        eofValid = 1'b0;
  logic [15:0] frameLen = '0;
  logic        crcOk = 1'b0, addrPass = 1'b0, isPause = 1'b0, noBuf = 1'b0;
  logic        rxEnable = 1'b0;
  logic [15:0] maxLen = 16'd100;
  logic        rdEn = 1'b0;
  logic [1:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic [3:0]  rdDataN;

  int total = 0;
  int bad = 0;
  int model [4];

  always #5 clk = ~clk;

  rx_size_err_stats u_dut (
    .clk(clk), .rstN(rstN), .eofValid(eofValid), .frameLen(frameLen),
    .crcOk(crcOk), .addrPass(addrPass), .isPause(isPause), .noBuf(noBuf),
    .rxEnable(rxEnable), .maxLen(maxLen), .rdEn(rdEn), .rdAddr(rdAddr),
    .rdData(rdData)
  );

  rx_size_err_stats #(.CNT_W(4)) u_dutNarrow (
    .clk(clk), .rstN(rstN), .eofValid(eofValid), .frameLen(frameLen),
    .crcOk(crcOk), .addrPass(addrPass), .isPause(isPause), .noBuf(noBuf),
    .rxEnable(rxEnable), .maxLen(maxLen), .rdEn(rdEn), .rdAddr(rdAddr),
    .rdData(rdDataN)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] lenOf(input int i);
    case (i)
      0: return 16'd0;     1: return 16'd1;    2: return 16'd63;
      3: return 16'd64;    4: return 16'd65;   5: return 16'd99;
      6: return 16'd100;   7: return 16'd101;  default: return 16'd1518;
    endcase
  endfunction

  task automatic sendFrame(input logic [15:0] len, input logic crc, input logic ap,
                           input logic pause, input logic nb, input logic en);
    @(negedge clk);
    eofValid = 1'b1; frameLen = len; crcOk = crc; addrPass = ap;
    isPause = pause; noBuf = nb; rxEnable = en;
    if (en && ap) begin
      if (len < 16'd64) begin
        if (crc) model[0]++; else model[1]++;
      end
      if (len > maxLen) model[2]++;
      if (nb && !pause) model[3]++;
    end
    @(negedge clk);
    eofValid = 1'b0;
  endtask

  task automatic readCnt(input int idx, output logic [31:0] val);
    @(negedge clk);
    rdEn = 1'b1; rdAddr = 2'(idx);
    @(negedge clk);
    rdEn = 1'b0;
    val = rdData;
  endtask

  task automatic readAll(input string req);
    logic [31:0] v;
    for (int k = 0; k < 4; k++) begin
      readCnt(k, v);
      chk($sformatf("%s idx%0d", req, k), v, 32'(model[k]));
      model[k] = 0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=running exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    for (int k = 0; k < 4; k++) model[k] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 rdData", rdData, 0);
    readAll("R1 reset counters");

    // R10: side inputs toggle with no end-of-frame strobe
    @(negedge clk);
    rxEnable = 1'b1; addrPass = 1'b1; noBuf = 1'b1; frameLen = 16'd10; crcOk = 1'b1;
    repeat (5) @(negedge clk);
    frameLen = 16'd3000; crcOk = 1'b0;
    repeat (5) @(negedge clk);
    readAll("R10 no strobe");

    // Sweep: R2 R3 R4 R5 R6 over lengths, flags and two maximum sizes
    for (int m = 0; m < 2; m++) begin
      @(negedge clk);
      maxLen = (m == 0) ? 16'd100 : 16'd1518;
      for (int li = 0; li < 9; li++) begin
        for (int c = 0; c < 32; c++) begin
          sendFrame(lenOf(li), c[0], c[1], c[2], c[3], c[4]);
          readAll($sformatf("R2 R3 R4 R5 R6 len=%0d flags=%0d", lenOf(li), c));
        end
      end
    end

    // R4: maximum size sampled in the end-of-frame cycle
    @(negedge clk);
    maxLen = 16'd200;
    sendFrame(16'd150, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    maxLen = 16'd120;
    sendFrame(16'd150, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    readAll("R4 maxLen change");

    // R8: read and increment of one counter in the same cycle
    for (int n = 0; n < 3; n++) sendFrame(16'd20, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    eofValid = 1'b1; frameLen = 16'd20; crcOk = 1'b1; addrPass = 1'b1;
    isPause = 1'b0; noBuf = 1'b0; rxEnable = 1'b1;
    rdEn = 1'b1; rdAddr = 2'd0;
    @(negedge clk);
    eofValid = 1'b0; rdEn = 1'b0;
    chk("R8 pre-increment value", rdData, 3);
    readCnt(0, v);
    chk("R8 restart at one", v, 1);
    model[0] = 0;

    // R7: read clears, second read returns zero
    sendFrame(16'd2000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    readCnt(2, v);
    chk("R7 first read", v, 1);
    readCnt(2, v);
    chk("R7 cleared", v, 0);
    model[2] = 0;

    // R9: narrow instance saturates at 15, wide one keeps counting
    for (int n = 0; n < 20; n++) sendFrame(16'd30, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    rdEn = 1'b1; rdAddr = 2'd1;
    @(negedge clk);
    rdEn = 1'b0;
    chk("R9 saturated narrow", 32'(rdDataN), 15);
    chk("R9 wide count", rdData, 20);
    model[1] = 0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule